// File: doc/BRIEF.md
# RMS Over/Under-Voltage Event Qualifier

This block turns a stream of per-line-cycle RMS voltage results into two debounced fault flags. Each RMS result arrives as a 16-bit unsigned value with a single-cycle valid strobe, once per line cycle. One flag reports overvoltage and the other reports undervoltage. A flag sets only after its condition has held on a programmable number of consecutive results.

Each threshold is a coarse 6-bit field, scaled so that it covers the whole 16-bit RMS range: the compare level is the field shifted left by ten bits. Both flags share one 6-bit qualification field. A field value of N requires N+1 consecutive qualifying results. Each flag has its own run counter. A change to any configuration field restarts qualification for both flags.

Top module: `rms_event_qual`

## Requirements
- R1: The overvoltage condition is the strict compare `rms_i > (ov_th_i << 10)`. An RMS value equal to that level does not qualify.
- R2: The undervoltage condition is the strict compare `rms_i < (uv_th_i << 10)`. An RMS value equal to that level does not qualify, so a field of 0 never qualifies.
- R3: With `qual_cnt_i` = N, a flag sets at the clock edge that samples the (N+1)th consecutive valid result meeting its condition. N = 0 sets the flag on the first such result, and N = 63 sets it on the 64th.
- R4: On cycles where `rms_vld_i` is low, the run counters and both flags hold their state, whatever `rms_i` carries.
- R5: A valid result that fails a flag's condition clears that flag's counter. The flag drops at that same edge.
- R6: A set flag stays set while each following valid result still meets its condition. The counter saturates and does not wrap.
- R7: The two flags qualify independently, each with its own counter, against the one shared count field. Both flags may be set together when the thresholds overlap.
- R8: A change to any of `ov_th_i`, `uv_th_i` or `qual_cnt_i` clears both counters and both flags at the next edge. A valid result that arrives in the cycle of the change is not counted.
- R9: An active-low `rst_ni` clears both counters and both flags asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rms_i | input | 16 | Unsigned RMS voltage result |
| rms_vld_i | input | 1 | One-cycle strobe marking a new RMS result |
| ov_th_i | input | 6 | Overvoltage threshold field, level = field << 10 |
| uv_th_i | input | 6 | Undervoltage threshold field, level = field << 10 |
| qual_cnt_i | input | 6 | Consecutive results required, minus one |
| ov_flag_o | output | 1 | Qualified overvoltage flag |
| uv_flag_o | output | 1 | Qualified undervoltage flag |

## Verification
The bench drives RMS values exactly at each scaled threshold and one LSB past it. A design that compares with greater-or-equal or less-or-equal would then set a flag one result early, or fail to drop it on time. It runs qualification counts of 0 and 63 and keeps feeding results after the flag has set. These runs catch an off-by-one in the N+1 mapping, and a counter that wraps and drops a held flag. Non-valid cycles carry values that would flip the condition, which exposes a counter that ignores the strobe. A valid result is presented in the same cycle as a configuration change, so a design that counts that result would set its flag one result early.

// File: rtl/rms_evq_pkg.sv
package rms_evq_pkg;
  localparam int unsigned RMS_W_DEF = 16;
  localparam int unsigned FLD_W_DEF = 6;

  typedef enum logic {
    CMP_ABOVE = 1'b0,
    CMP_BELOW = 1'b1
  } cmp_dir_e;
endpackage

// File: rtl/rms_evq_cmp.sv
module rms_evq_cmp
  import rms_evq_pkg::*;
#(
  parameter int unsigned RMS_W = RMS_W_DEF,
  parameter int unsigned FLD_W = FLD_W_DEF,
  parameter cmp_dir_e    DIR   = CMP_ABOVE
) (
  input  logic [RMS_W-1:0] rms_i,
  input  logic [FLD_W-1:0] th_i,
  output logic             hit_o
);
  localparam int unsigned SHIFT = RMS_W - FLD_W;

  logic [RMS_W-1:0] level;
  assign level = {th_i, {SHIFT{1'b0}}};

  // strict compare in both directions
  if (DIR == CMP_ABOVE) begin : g_above
    assign hit_o = rms_i > level;
  end else begin : g_below
    assign hit_o = rms_i < level;
  end
endmodule

// File: rtl/rms_evq_cfg_mon.sv
module rms_evq_cfg_mon #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cfg_i,
  output logic         chg_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  assign chg_o = cfg_i != cfg_q;
endmodule

// File: rtl/rms_evq_qual.sv
module rms_evq_qual
  import rms_evq_pkg::*;
#(
  parameter int unsigned FLD_W = FLD_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             hit_i,
  input  logic             clr_i,
  input  logic [FLD_W-1:0] need_i,
  output logic             flag_o
);
  localparam int unsigned CNT_W = FLD_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, need_full, cnt_inc;
  logic             flag_q, flag_d;

  assign need_full = {1'b0, need_i} + CNT_W'(1);
  // saturate at the required run length
  assign cnt_inc   = (cnt_q >= need_full) ? need_full : cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (clr_i) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (vld_i) begin
      if (hit_i) begin
        cnt_d  = cnt_inc;
        flag_d = cnt_inc == need_full;
      end else begin
        cnt_d  = '0;
        flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q <= need_full);

  assert_hold_no_vld_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> ($stable(flag_o) && $stable(cnt_q)));

  assert_drop_on_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !hit_i && !clr_i) |=> (!flag_o && cnt_q == '0));

  assert_clear_on_cfg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!flag_o && cnt_q == '0));

  assert_rise_needs_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(vld_i && hit_i && !clr_i));
endmodule

// File: rtl/rms_event_qual.sv
module rms_event_qual
  import rms_evq_pkg::*;
#(
  parameter int unsigned RMS_W = RMS_W_DEF,
  parameter int unsigned FLD_W = FLD_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RMS_W-1:0] rms_i,
  input  logic             rms_vld_i,
  input  logic [FLD_W-1:0] ov_th_i,
  input  logic [FLD_W-1:0] uv_th_i,
  input  logic [FLD_W-1:0] qual_cnt_i,
  output logic             ov_flag_o,
  output logic             uv_flag_o
);
  localparam int unsigned CFG_W = 3 * FLD_W;
  localparam int unsigned N_CH  = 2;  // 0: overvoltage, 1: undervoltage

  logic            cfg_chg;
  logic [N_CH-1:0] hit, flag;

  rms_evq_cfg_mon #(.W(CFG_W)) u_cfg_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  ({ov_th_i, uv_th_i, qual_cnt_i}),
    .chg_o  (cfg_chg)
  );

  rms_evq_cmp #(.RMS_W(RMS_W), .FLD_W(FLD_W), .DIR(CMP_ABOVE)) u_cmp_ov (
    .rms_i (rms_i),
    .th_i  (ov_th_i),
    .hit_o (hit[0])
  );

  rms_evq_cmp #(.RMS_W(RMS_W), .FLD_W(FLD_W), .DIR(CMP_BELOW)) u_cmp_uv (
    .rms_i (rms_i),
    .th_i  (uv_th_i),
    .hit_o (hit[1])
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    rms_evq_qual #(.FLD_W(FLD_W)) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (rms_vld_i),
      .hit_i  (hit[g]),
      .clr_i  (cfg_chg),
      .need_i (qual_cnt_i),
      .flag_o (flag[g])
    );
  end

  assign ov_flag_o = flag[0];
  assign uv_flag_o = flag[1];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R9: assert (!ov_flag_o && !uv_flag_o);
    end
  end

  assert_ov_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ov_flag_o) |-> $past(rms_vld_i && rms_i > {ov_th_i, {(RMS_W-FLD_W){1'b0}}}));

  assert_uv_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uv_flag_o) |-> $past(rms_vld_i && rms_i < {uv_th_i, {(RMS_W-FLD_W){1'b0}}}));
endmodule

// File: tb/rms_event_qual_bench.sv
module rms_event_qual_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 21;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] rms = '0;
  logic        vld = 1'b0;
  logic [5:0]  ov_th = '0, uv_th = '0, qcnt = '0;
  logic        ov_flag, uv_flag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rms_event_qual u_rms_event_qual (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rms_i      (rms),
    .rms_vld_i  (vld),
    .ov_th_i    (ov_th),
    .uv_th_i    (uv_th),
    .qual_cnt_i (qcnt),
    .ov_flag_o  (ov_flag),
    .uv_flag_o  (uv_flag)
  );

  // {rms, vld, exp_ov, exp_uv}; config ov=20 (20480), uv=10 (10240), count=2 (3 results)
  localparam logic [18:0] VEC [N_VEC] = '{
    {16'd15000, 1'b0, 1'b0, 1'b0},  // cfg change cycle, R8
    {16'd20481, 1'b1, 1'b0, 1'b0},  // R1 one past level, run 1
    {16'd30000, 1'b1, 1'b0, 1'b0},  // run 2
    {16'd30000, 1'b0, 1'b0, 1'b0},  // R4 hold
    {16'd25000, 1'b1, 1'b1, 1'b0},  // R3 third result sets
    {16'd25000, 1'b1, 1'b1, 1'b0},  // R6 stays
    {16'd20480, 1'b1, 1'b0, 1'b0},  // R1 equal -> R5 drop
    {16'd10239, 1'b1, 1'b0, 1'b0},  // R2 run 1
    {16'd0,     1'b1, 1'b0, 1'b0},  // run 2
    {16'd5000,  1'b1, 1'b0, 1'b1},  // R3 sets
    {16'd10240, 1'b1, 1'b0, 1'b0},  // R2 equal -> R5 drop
    {16'd10000, 1'b1, 1'b0, 1'b0},  // run 1
    {16'd15000, 1'b1, 1'b0, 1'b0},  // neither, R5
    {16'd65535, 1'b1, 1'b0, 1'b0},
    {16'd65535, 1'b1, 1'b0, 1'b0},
    {16'd100,   1'b1, 1'b0, 1'b0},  // ov run broken, R5
    {16'd100,   1'b1, 1'b0, 1'b0},
    {16'd100,   1'b1, 1'b0, 1'b1},
    {16'd100,   1'b0, 1'b0, 1'b1},  // R4 hold
    {16'd20000, 1'b0, 1'b0, 1'b1},  // R4 value ignored without strobe
    {16'd20000, 1'b1, 1'b0, 1'b0}   // R5 drop
  };

  task automatic check(input logic eov, input logic euv, input string tag);
    checks++;
    if (ov_flag !== eov || uv_flag !== euv) begin
      errors++;
      $display("FAIL %s: ov=%0b uv=%0b expected ov=%0b uv=%0b", tag, ov_flag, uv_flag, eov, euv);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic [5:0] o, input logic [5:0] u, input logic [5:0] c,
                      input logic [15:0] r, input logic v);
    ov_th = o; uv_th = u; qcnt = c; rms = r; vld = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check(1'b0, 1'b0, "R9 reset state");
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      step(6'd20, 6'd10, 6'd2, VEC[i][18:3], VEC[i][2]);
      check(VEC[i][1], VEC[i][0], $sformatf("R1/R2/R3/R4/R5/R6 vector %0d", i));
    end

    // R3: count 0 sets on first qualifying result
    step(6'd1, 6'd0, 6'd0, 16'd2000, 1'b0);
    check(1'b0, 1'b0, "R8 cfg change");
    step(6'd1, 6'd0, 6'd0, 16'd2000, 1'b1);
    check(1'b1, 1'b0, "R3 count 0");

    // R9: async reset clears a set flag
    rst_ni = 1'b0;
    #1;
    check(1'b0, 1'b0, "R9 async reset");
    @(negedge clk);
    rst_ni = 1'b1;

    // R3/R6: count 63 needs 64 results, then saturates
    step(6'd0, 6'd0, 6'd63, 16'd1, 1'b0);
    for (int i = 0; i < 63; i++) begin
      step(6'd0, 6'd0, 6'd63, 16'd1, 1'b1);
      check(1'b0, 1'b0, "R3 count 63 before 64th");
    end
    step(6'd0, 6'd0, 6'd63, 16'd1, 1'b1);
    check(1'b1, 1'b0, "R3 count 63 at 64th");
    for (int i = 0; i < 10; i++) begin
      step(6'd0, 6'd0, 6'd63, 16'd1, 1'b1);
      check(1'b1, 1'b0, "R6 saturated hold");
    end

    // R8: change with a valid result clears and does not count it
    step(6'd0, 6'd0, 6'd1, 16'd5, 1'b1);
    check(1'b0, 1'b0, "R8 count change clears flag");
    step(6'd0, 6'd0, 6'd1, 16'd5, 1'b1);
    check(1'b0, 1'b0, "R8 change-cycle result not counted");
    step(6'd0, 6'd0, 6'd1, 16'd5, 1'b1);
    check(1'b1, 1'b0, "R8 second result after change");
    step(6'd0, 6'd1, 6'd1, 16'd5000, 1'b1);
    check(1'b0, 1'b0, "R8 uv field change clears ov flag");
    step(6'd0, 6'd1, 6'd1, 16'd5000, 1'b1);
    check(1'b0, 1'b0, "R8 restart run 1");
    step(6'd0, 6'd1, 6'd1, 16'd5000, 1'b1);
    check(1'b1, 1'b0, "R8 restart run 2");

    // R7: overlapping thresholds, independent counters
    step(6'd5, 6'd40, 6'd0, 16'd20000, 1'b0);
    check(1'b0, 1'b0, "R7 cfg change");
    step(6'd5, 6'd40, 6'd0, 16'd20000, 1'b1);
    check(1'b1, 1'b1, "R7 both set");
    step(6'd5, 6'd40, 6'd0, 16'd3000, 1'b1);
    check(1'b0, 1'b1, "R7 ov drops alone");
    step(6'd5, 6'd40, 6'd0, 16'd50000, 1'b1);
    check(1'b1, 1'b0, "R7 uv drops alone");

    finish_run();
  end
endmodule